// File: doc/BRIEF.md
# Sector Write-Lock Manager

This block tracks write protection for the 71 erase sectors of a 2M x 16 flash array. Each sector holds two flags: a soft lock that commands can set and clear, and a hard lock that commands can set but only reset can clear. A write-protect input decides whether an active hard lock blocks unlocking and writes. The command front end hands over a decoded lock command as a sector index plus its confirm byte. Any other block can ask, without waiting a cycle, whether program or erase is allowed for a given sector index and read back that sector's two-bit protection status.

A separate address-to-sector decoder in the same top maps a 21-bit word address onto the mixed sector sizes. Eight 4K-word sectors sit at one end of the array and sixty-three 32K-word sectors fill the rest. A parameter places the small sectors at the bottom or at the top. The mapping uses address bit slices only, with no lookup table.

Lock commands use a valid/ready handshake. A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low during reset and high from the first clock after reset, so the block never stalls a sender once it is running. A sender may hold `cmd_valid` with stable fields for as long as it needs to. Each accepted cycle counts as one command.

Top module: `sector_lock_mgr`

## Requirements
- R1: After reset every sector reads status 01 (soft lock set, hard lock clear) and program/erase is denied.
- R2: An accepted command acts on sector `cmd_sector`, and its effect is visible from the next clock. Code D0h unlocks the sector, code 01h sets its soft lock, and code 2Fh sets both its hard lock and its soft lock. Any other code changes nothing.
- R3: With `wp` low and the hard lock set, unlock (D0h) leaves the soft lock set.
- R4: With `wp` high, unlock clears the soft lock even when the hard lock is set, so the sector reads status 10 and is writable.
- R5: `qry_allow` is high only when `pgm_en` is high, the soft lock is clear, and either the hard lock is clear or `wp` is high. With `pgm_en` low, every sector is denied.
- R6: No command clears a hard lock. Only reset clears it.
- R7: `qry_status` carries the soft lock on bit 0 and the hard lock on bit 1: 00 none, 01 soft, 10 hard, 11 both.
- R8: A command whose sector index is 71 or above changes no sector. A query at index 71 or above returns allow 0 and status 00.
- R9: With bottom boot (TOP_BOOT=0), an address with bits [20:15] = 0 maps to sector bits [14:12] (0..7). Any other address maps to 7 + bits [20:15].
- R10: With top boot (TOP_BOOT=1), an address with bits [20:15] = 63 maps to 63 + bits [14:12]. Any other address maps to bits [20:15].
- R11: `cmd_ready` is high from the first clock after reset. A cycle with `cmd_valid` low changes no sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restores every sector to the soft-locked state |
| cmd_valid | input | 1 | A lock command is presented |
| cmd_ready | output | 1 | The block accepts a command this cycle |
| cmd_sector | input | 7 | Target sector index of the command |
| cmd_code | input | 8 | Confirm byte: D0h unlock, 01h soft lock, 2Fh hard lock |
| wp | input | 1 | Write-protect level; high overrides the hard lock |
| pgm_en | input | 1 | Program supply good; low denies all writes |
| qry_sector | input | 7 | Sector index to query |
| qry_allow | output | 1 | Program/erase allowed for the queried sector |
| qry_status | output | 2 | {hard, soft} lock bits of the queried sector |
| dec_addr | input | 21 | Word address to decode |
| dec_sector | output | 7 | Sector index holding `dec_addr` |

## Verification
A wrong lock flag shows on `qry_status` and `qry_allow` in the first cycle after the command that caused it, because the query path has no register. A hard lock cleared by mistake would show status bit 1 low, and the bench looks for this after unlock attempts with `wp` both low and high. A wrong decoder slice shows at once as a wrong `dec_sector` at the edges of the small-sector and large-sector ranges, and the bench checks those edges for both layouts.

// File: rtl/sector_lock_pkg.sv
package sector_lock_pkg;
  localparam int ADDR_W   = 21;
  localparam int SMALL_W  = 12;
  localparam int BIG_W    = 15;
  localparam int N_SMALL  = 1 << (BIG_W - SMALL_W);
  localparam int N_BIG    = (1 << (ADDR_W - BIG_W)) - 1;
  localparam int N_SECT   = N_SMALL + N_BIG;
  localparam int IDX_W    = $clog2(N_SECT + 1);

  typedef enum logic [7:0] {
    CODE_SOFT   = 8'h01,
    CODE_HARD   = 8'h2F,
    CODE_UNLOCK = 8'hD0
  } lock_code_e;
endpackage

// File: rtl/sector_addr_dec.sv
module sector_addr_dec
  import sector_lock_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  sector
);
  localparam int HI_W = ADDR_W - BIG_W;
  localparam int LO_W = BIG_W - SMALL_W;

  logic [HI_W-1:0] hi_field;
  logic [LO_W-1:0] lo_field;

  assign hi_field = addr[ADDR_W-1:BIG_W];
  assign lo_field = addr[BIG_W-1:SMALL_W];

  generate
    if (TOP_BOOT) begin : g_top
      always_comb begin
        if (hi_field == {HI_W{1'b1}})
          sector = IDX_W'(N_BIG) + IDX_W'(lo_field);
        else
          sector = IDX_W'(hi_field);
      end
    end else begin : g_bottom
      always_comb begin
        if (hi_field == '0)
          sector = IDX_W'(lo_field);
        else
          sector = IDX_W'(N_SMALL - 1) + IDX_W'(hi_field);
      end
    end
  endgenerate
endmodule

// File: rtl/sector_lock_cell.sv
module sector_lock_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic do_soft,
  input  logic do_hard,
  input  logic do_unlock,
  input  logic wp,
  output logic soft_q,
  output logic hard_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q <= 1'b1;
      hard_q <= 1'b0;
    end else if (hit) begin
      if (do_hard) begin
        hard_q <= 1'b1;
        soft_q <= 1'b1;
      end else if (do_soft) begin
        soft_q <= 1'b1;
      end else if (do_unlock && (!hard_q || wp)) begin
        soft_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sector_lock_mgr.sv
module sector_lock_mgr
  import sector_lock_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [IDX_W-1:0]  cmd_sector,
  input  logic [7:0]        cmd_code,
  input  logic              wp,
  input  logic              pgm_en,
  input  logic [IDX_W-1:0]  qry_sector,
  output logic              qry_allow,
  output logic [1:0]        qry_status,
  input  logic [ADDR_W-1:0] dec_addr,
  output logic [IDX_W-1:0]  dec_sector
);
  logic              accept;
  logic              cmd_in_range;
  logic              op_soft;
  logic              op_hard;
  logic              op_unlock;
  logic [N_SECT-1:0] soft_vec;
  logic [N_SECT-1:0] hard_vec;
  logic              q_in_range;
  logic              q_soft;
  logic              q_hard;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_ready <= 1'b0;
    else        cmd_ready <= 1'b1;
  end

  assign accept       = cmd_valid && cmd_ready;
  assign cmd_in_range = cmd_sector < IDX_W'(N_SECT);
  assign op_soft      = accept && cmd_in_range && (cmd_code == CODE_SOFT);
  assign op_hard      = accept && cmd_in_range && (cmd_code == CODE_HARD);
  assign op_unlock    = accept && cmd_in_range && (cmd_code == CODE_UNLOCK);

  generate
    for (genvar s = 0; s < N_SECT; s++) begin : g_sect
      sector_lock_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (cmd_sector == IDX_W'(s)),
        .do_soft   (op_soft),
        .do_hard   (op_hard),
        .do_unlock (op_unlock),
        .wp        (wp),
        .soft_q    (soft_vec[s]),
        .hard_q    (hard_vec[s])
      );
    end
  endgenerate

  assign q_in_range = qry_sector < IDX_W'(N_SECT);

  always_comb begin
    q_soft = 1'b0;
    q_hard = 1'b0;
    for (int s = 0; s < N_SECT; s++) begin
      if (qry_sector == IDX_W'(s)) begin
        q_soft = soft_vec[s];
        q_hard = hard_vec[s];
      end
    end
  end

  assign qry_status = {q_hard, q_soft};
  assign qry_allow  = pgm_en && q_in_range && !q_soft && (!q_hard || wp);

  sector_addr_dec #(.TOP_BOOT(TOP_BOOT)) u_dec (
    .addr   (dec_addr),
    .sector (dec_sector)
  );
endmodule

// File: rtl/sector_lock_mgr_chk.sv
module sector_lock_mgr_chk
  import sector_lock_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [IDX_W-1:0]  cmd_sector,
  input logic [7:0]        cmd_code,
  input logic              wp,
  input logic              pgm_en,
  input logic              qry_allow,
  input logic [1:0]        qry_status,
  input logic [IDX_W-1:0]  dec_sector,
  input logic [N_SECT-1:0] soft_vec,
  input logic [N_SECT-1:0] hard_vec
);
  // R11: the handshake is open from the first clock after reset
  a_r11_ready_up: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cmd_ready);

  // R8: commands aimed past the last sector touch nothing
  a_r8_oor_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_sector >= IDX_W'(N_SECT))
      |=> ($stable(soft_vec) && $stable(hard_vec)));

  // R5: a granted write implies supply good and no soft lock reported
  a_r5_allow_gated: assert property (@(posedge clk) disable iff (!rst_n)
    qry_allow |-> (pgm_en && !qry_status[0]));

  // R9: decoded index always names a real sector
  a_r9_dec_range: assert property (@(posedge clk) disable iff (!rst_n)
    dec_sector < IDX_W'(N_SECT));

  generate
    for (genvar s = 0; s < N_SECT; s++) begin : g_chk
      // R6: once set, a hard lock stays set until reset
      a_r6_hard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        hard_vec[s] |=> hard_vec[s]);

      // R3: unlock under an unoverridden hard lock keeps the soft lock
      a_r3_unlock_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_sector == IDX_W'(s) &&
         cmd_code == 8'hD0 && hard_vec[s] && !wp) |=> soft_vec[s]);
    end
  endgenerate
endmodule

bind sector_lock_mgr sector_lock_mgr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_sector (cmd_sector),
  .cmd_code   (cmd_code),
  .wp         (wp),
  .pgm_en     (pgm_en),
  .qry_allow  (qry_allow),
  .qry_status (qry_status),
  .dec_sector (dec_sector),
  .soft_vec   (soft_vec),
  .hard_vec   (hard_vec)
);

// File: tb/sector_lock_mgr_tb.sv
module sector_lock_mgr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [6:0]  cmd_sector = '0;
  logic [7:0]  cmd_code = '0;
  logic        wp = 1'b0;
  logic        pgm_en = 1'b1;
  logic [6:0]  qry_sector = '0;
  logic [20:0] dec_addr = '0;
  logic        cmd_ready, cmd_ready_t;
  logic        qry_allow, qry_allow_t;
  logic [1:0]  qry_status, qry_status_t;
  logic [6:0]  dec_sector, dec_sector_t;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int    kind;
    int    exp_a;
    int    exp_b;
    string tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  sector_lock_mgr #(.TOP_BOOT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_sector(cmd_sector), .cmd_code(cmd_code), .wp(wp), .pgm_en(pgm_en),
    .qry_sector(qry_sector), .qry_allow(qry_allow), .qry_status(qry_status),
    .dec_addr(dec_addr), .dec_sector(dec_sector)
  );

  sector_lock_mgr #(.TOP_BOOT(1'b1)) u_dut_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready_t),
    .cmd_sector(cmd_sector), .cmd_code(cmd_code), .wp(wp), .pgm_en(pgm_en),
    .qry_sector(qry_sector), .qry_allow(qry_allow_t), .qry_status(qry_status_t),
    .dec_addr(dec_addr), .dec_sector(dec_sector_t)
  );

  // monitor: pops expected items mid low phase and compares
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (sb.size() > 0) begin
        item_t it;
        int act_a;
        int act_b;
        it = sb.pop_front();
        act_b = 0;
        case (it.kind)
          0: begin act_a = int'(qry_allow); act_b = int'(qry_status); end
          1: act_a = int'(dec_sector);
          2: act_a = int'(dec_sector_t);
          default: act_a = int'(cmd_ready);
        endcase
        checks++;
        if (act_a != it.exp_a || act_b != it.exp_b) begin
          errors++;
          $display("FAIL %s: actual %0d/%0d expected %0d/%0d",
                   it.tag, act_a, act_b, it.exp_a, it.exp_b);
        end
      end
    end
  end

  task automatic chk_q(input int idx, input int allow, input int stat, input string tag);
    item_t it;
    @(negedge clk);
    qry_sector = 7'(idx);
    it.kind = 0; it.exp_a = allow; it.exp_b = stat; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chk_dec(input int addr, input int exp_sec, input int kind, input string tag);
    item_t it;
    @(negedge clk);
    dec_addr = 21'(addr);
    it.kind = kind; it.exp_a = exp_sec; it.exp_b = 0; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chk_ready(input string tag);
    item_t it;
    @(negedge clk);
    it.kind = 3; it.exp_a = 1; it.exp_b = 0; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic send_cmd(input int idx, input logic [7:0] code);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sector = 7'(idx); cmd_code = code;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    chk_ready("R11 ready after reset");
    chk_q(0, 0, 1, "R1 sector 0 reset");
    chk_q(7, 0, 1, "R1 sector 7 reset");
    chk_q(70, 0, 1, "R1 sector 70 reset");

    send_cmd(5, 8'hD0);
    chk_q(5, 1, 0, "R2 unlock sector 5");
    chk_q(6, 0, 1, "R2 neighbour untouched");
    send_cmd(6, 8'h55);
    chk_q(6, 0, 1, "R2 unknown code on locked");
    send_cmd(5, 8'h55);
    chk_q(5, 1, 0, "R2 unknown code on unlocked");
    send_cmd(5, 8'h01);
    chk_q(5, 0, 1, "R2 soft lock sector 5");

    send_cmd(9, 8'h2F);
    chk_q(9, 0, 3, "R7 hard lock reads 11");
    send_cmd(9, 8'hD0);
    chk_q(9, 0, 3, "R3 unlock blocked wp low");
    @(negedge clk) wp = 1'b1;
    send_cmd(9, 8'hD0);
    chk_q(9, 1, 2, "R4 unlock with wp high");
    @(negedge clk) wp = 1'b0;
    chk_q(9, 0, 2, "R5 hard blocks with wp low");
    send_cmd(9, 8'h01);
    chk_q(9, 0, 3, "R6 soft relock keeps hard");
    @(negedge clk) wp = 1'b1;
    send_cmd(9, 8'hD0);
    send_cmd(9, 8'h00);
    send_cmd(9, 8'hFF);
    chk_q(9, 1, 2, "R6 hard survives commands");
    @(negedge clk) wp = 1'b0;

    send_cmd(20, 8'hD0);
    chk_q(20, 1, 0, "R5 allowed with supply");
    @(negedge clk) pgm_en = 1'b0;
    chk_q(20, 0, 0, "R5 denied without supply");
    @(negedge clk) pgm_en = 1'b1;

    send_cmd(71, 8'hD0);
    send_cmd(127, 8'hD0);
    chk_q(70, 0, 1, "R8 index 71 ignored");
    chk_q(0, 0, 1, "R8 index 127 ignored");
    chk_q(100, 0, 0, "R8 query out of range");

    @(negedge clk);
    cmd_valid = 1'b0; cmd_sector = 7'd30; cmd_code = 8'hD0;
    @(negedge clk);
    chk_q(30, 0, 1, "R11 idle valid ignored");

    chk_dec('h00000, 0, 1, "R9 bottom 00000");
    chk_dec('h00FFF, 0, 1, "R9 bottom 00FFF");
    chk_dec('h01000, 1, 1, "R9 bottom 01000");
    chk_dec('h07FFF, 7, 1, "R9 bottom 07FFF");
    chk_dec('h08000, 8, 1, "R9 bottom 08000");
    chk_dec('h0FFFF, 8, 1, "R9 bottom 0FFFF");
    chk_dec('h10000, 9, 1, "R9 bottom 10000");
    chk_dec('h1FFFFF, 70, 1, "R9 bottom 1FFFFF");
    chk_dec('h00000, 0, 2, "R10 top 00000");
    chk_dec('h07FFF, 0, 2, "R10 top 07FFF");
    chk_dec('h08000, 1, 2, "R10 top 08000");
    chk_dec('h1F7FFF, 62, 2, "R10 top 1F7FFF");
    chk_dec('h1F8000, 63, 2, "R10 top 1F8000");
    chk_dec('h1F9000, 64, 2, "R10 top 1F9000");
    chk_dec('h1FFFFF, 70, 2, "R10 top 1FFFFF");

    do_reset();
    chk_q(9, 0, 1, "R6 reset clears hard");
    chk_q(20, 0, 1, "R1 reset relocks");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule